// File: doc/BRIEF.md
# One-Shot Link Configuration Handshake Register

This block is a small 32-bit register file placed behind an indirect register bus. It mediates a single link-configuration request from a host to an embedded configuration engine. The host writes one word to the control register. That word sets the request flag and gives an error-correction mode for each of eight links. The block hands the packed modes to the engine with a one-cycle launch pulse. It then waits for the engine to report completion.

When the engine finishes, the block sets a completion flag one cycle later and captures the two per-group status words that the engine presents. From that cycle on, it signals that the host owns the shared serial master. The request can be accepted only once per power-up. Every later request is dropped, and the stored modes do not change. A read-only version word comes from the controller. If that word is all zeros, no controller is present, and the host owns the serial master immediately.

Register map (word addresses, stride 4): control at 0x0, version at 0x4, group A status at 0x8, group B status at 0xC. Any other address reads as zero.

Top module: `cfg_handshake_regs`

## Requirements
- R1: After reset, reads of the control, group A and group B registers return zero. The launch pulse is low. With a nonzero version word, the ownership flag is low.
- R2: The control register keeps the completion flag at bit 0 and the request flag at bit 1. Link i (0..7) has its 2-bit mode at bits 8+2i+1 down to 8+2i. Links 0..3 form group A and links 4..7 form group B. Bits 7:2 and 31:24 read as zero.
- R3: A control write that has bit 1 set, made while neither flag is set, is accepted. In the cycle after the write, the launch output pulses high for exactly one cycle. From that cycle on, the mode output carries bits 23:8 of the write.
- R4: Mode codes are 0 = no correction, 1 = fire-code correction and 2 = Reed-Solomon correction. Code 3 is reserved, but it is stored and forwarded exactly as written, like the other codes.
- R5: After a request has been accepted, any further control write leaves the stored modes unchanged and produces no launch pulse. A control write with bit 1 clear is ignored.
- R6: An engine done indication sampled while a request is pending sets the completion flag at that clock edge, so the flag is visible one cycle after done was driven. The flag stays set until reset. A done indication with no pending request is ignored.
- R7: The ownership output is high whenever the completion flag is set or the version input is all zeros, and low otherwise.
- R8: The version register reads back the version input unchanged: patch in bits 23:20, minor in bits 27:24, major in bits 31:28.
- R9: At completion, the block captures the 16-bit status of each group: result in bits 15:8 (0 means success) and identifier in bits 7:0. Group A reads at 0x8 and group B at 0xC, with bits 31:16 reading as zero.
- R10: Read data and read valid are registered and appear one cycle after the read request. Unmapped or misaligned addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Register bus request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| fw_version_i | input | 32 | Controller version word |
| eng_start_o | output | 1 | One-cycle launch pulse to engine |
| eng_mode_o | output | 16 | Packed per-link modes |
| eng_done_i | input | 1 | Engine completion indication |
| grp_a_stat_i | input | 16 | Group A status from engine |
| grp_b_stat_i | input | 16 | Group B status from engine |
| host_owns_o | output | 1 | Host owns the shared serial master |

## Verification
Each result has its own latency, and each check waits exactly that long:
- The launch pulse and the mode output appear in the cycle after the accepted write. The bench checks them at the falling edge after that write's rising edge, and checks again one cycle later that the pulse has gone low.
- The completion flag and the ownership output change at the edge that samples done. The bench checks them at the following falling edge.
- Read data is registered and sampled one falling edge after the request edge.
- The version-zero case reaches the ownership output combinationally, so it is checked within the same cycle.

The bench resets before each of four mode patterns, so every link takes every code value, including the reserved one.

// File: rtl/cfg_hs_pkg.sv
package cfg_hs_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned DONE_BIT  = 0;
    localparam int unsigned START_BIT = 1;
    localparam int unsigned MODE_LSB  = 8;
    localparam int unsigned STAT_W    = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_VER,
        SEL_GRPA,
        SEL_GRPB
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] result;
        logic [7:0] ident;
    } grp_stat_t;

    function automatic logic [DATA_W-1:0] stat_word(input grp_stat_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[STAT_W-1:0] = s;
        return w;
    endfunction

endpackage

// File: rtl/cfg_hs_decode.sv
module cfg_hs_decode
    import cfg_hs_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);
    localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_VER  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFF_GRPA = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFF_GRPB = ADDR_W'(12);

    always_comb begin
        sel_o = SEL_NONE;
        if (addr_i[1:0] == 2'b00) begin
            case (addr_i)
                OFF_CTRL: sel_o = SEL_CTRL;
                OFF_VER:  sel_o = SEL_VER;
                OFF_GRPA: sel_o = SEL_GRPA;
                OFF_GRPB: sel_o = SEL_GRPB;
                default:  sel_o = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_hs_core.sv
module cfg_hs_core
    import cfg_hs_pkg::*;
#(
    parameter int unsigned N_LINKS = 8,
    parameter int unsigned MODE_W  = 2,
    localparam int unsigned MODES_W = N_LINKS * MODE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctrl_wr_i,
    input  logic               wr_start_i,
    input  logic [MODES_W-1:0] wr_modes_i,
    input  logic               eng_done_i,
    input  grp_stat_t          grp_a_i,
    input  grp_stat_t          grp_b_i,
    output logic               start_q,
    output logic               done_q,
    output logic [MODES_W-1:0] modes_q,
    output logic               launch_q,
    output grp_stat_t          grp_a_q,
    output grp_stat_t          grp_b_q
);
    logic accept;
    logic finish;

    assign accept = ctrl_wr_i & wr_start_i & ~start_q & ~done_q;
    assign finish = eng_done_i & start_q & ~done_q;

    for (genvar g = 0; g < N_LINKS; g++) begin : g_link
        always_ff @(posedge clk) begin
            if (rst) begin
                modes_q[g*MODE_W +: MODE_W] <= '0;
            end else if (accept) begin
                modes_q[g*MODE_W +: MODE_W] <= wr_modes_i[g*MODE_W +: MODE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q  <= 1'b0;
            done_q   <= 1'b0;
            launch_q <= 1'b0;
            grp_a_q  <= '0;
            grp_b_q  <= '0;
        end else begin
            launch_q <= accept;
            if (accept) begin
                start_q <= 1'b1;
            end
            if (finish) begin
                done_q  <= 1'b1;
                grp_a_q <= grp_a_i;
                grp_b_q <= grp_b_i;
            end
        end
    end
endmodule

// File: rtl/cfg_hs_rdmux.sv
module cfg_hs_rdmux
    import cfg_hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_i,
    input  reg_sel_e          sel_i,
    input  logic [DATA_W-1:0] ctrl_word_i,
    input  logic [DATA_W-1:0] ver_word_i,
    input  logic [DATA_W-1:0] grpa_word_i,
    input  logic [DATA_W-1:0] grpb_word_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] pick;

    always_comb begin
        case (sel_i)
            SEL_CTRL: pick = ctrl_word_i;
            SEL_VER:  pick = ver_word_i;
            SEL_GRPA: pick = grpa_word_i;
            SEL_GRPB: pick = grpb_word_i;
            default:  pick = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_en_i;
            rd_data_o  <= rd_en_i ? pick : '0;
        end
    end
endmodule

// File: rtl/cfg_handshake_regs.sv
module cfg_handshake_regs
    import cfg_hs_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned N_LINKS = 8,
    parameter int unsigned MODE_W  = 2,
    localparam int unsigned MODES_W = N_LINKS * MODE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid_i,
    input  logic               req_write_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    input  logic [31:0]        req_wdata_i,
    output logic               rd_valid_o,
    output logic [31:0]        rd_data_o,
    input  logic [31:0]        fw_version_i,
    output logic               eng_start_o,
    output logic [MODES_W-1:0] eng_mode_o,
    input  logic               eng_done_i,
    input  logic [15:0]        grp_a_stat_i,
    input  logic [15:0]        grp_b_stat_i,
    output logic               host_owns_o
);
    reg_sel_e           sel;
    logic               start_q;
    logic               done_q;
    logic [MODES_W-1:0] modes_q;
    grp_stat_t          grp_a_q;
    grp_stat_t          grp_b_q;
    logic [DATA_W-1:0]  ctrl_word;
    logic               ctrl_wr;
    logic               rd_en;

    assign ctrl_wr = req_valid_i & req_write_i & (sel == SEL_CTRL);
    assign rd_en   = req_valid_i & ~req_write_i;

    cfg_hs_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (req_addr_i),
        .sel_o  (sel)
    );

    cfg_hs_core #(.N_LINKS(N_LINKS), .MODE_W(MODE_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr_i  (ctrl_wr),
        .wr_start_i (req_wdata_i[START_BIT]),
        .wr_modes_i (req_wdata_i[MODE_LSB +: MODES_W]),
        .eng_done_i (eng_done_i),
        .grp_a_i    (grp_stat_t'(grp_a_stat_i)),
        .grp_b_i    (grp_stat_t'(grp_b_stat_i)),
        .start_q    (start_q),
        .done_q     (done_q),
        .modes_q    (modes_q),
        .launch_q   (eng_start_o),
        .grp_a_q    (grp_a_q),
        .grp_b_q    (grp_b_q)
    );

    always_comb begin
        ctrl_word = '0;
        ctrl_word[DONE_BIT]  = done_q;
        ctrl_word[START_BIT] = start_q;
        ctrl_word[MODE_LSB +: MODES_W] = modes_q;
    end

    cfg_hs_rdmux u_rd (
        .clk         (clk),
        .rst         (rst),
        .rd_en_i     (rd_en),
        .sel_i       (sel),
        .ctrl_word_i (ctrl_word),
        .ver_word_i  (fw_version_i),
        .grpa_word_i (stat_word(grp_a_q)),
        .grpb_word_i (stat_word(grp_b_q)),
        .rd_valid_o  (rd_valid_o),
        .rd_data_o   (rd_data_o)
    );

    assign eng_mode_o  = modes_q;
    assign host_owns_o = done_q | (fw_version_i == '0);
endmodule

// File: rtl/cfg_hs_chk.sv
module cfg_hs_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid_i,
    input logic        req_write_i,
    input logic        rd_valid_o,
    input logic        eng_start_o,
    input logic [15:0] eng_mode_o,
    input logic        eng_done_i,
    input logic        host_owns_o,
    input logic        start_q,
    input logic        done_q
);
    // R3
    launch_single_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start_o |=> !eng_start_o);
    // R3
    launch_cause_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start_o |-> start_q);
    // R5
    modes_hold_chk: assert property (@(posedge clk) disable iff (rst)
        start_q |=> $stable(eng_mode_o));
    // R6
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(eng_done_i));
    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> done_q);
    // R7
    owner_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> host_owns_o);
    // R10
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> $past(req_valid_i && !req_write_i));
endmodule

bind cfg_handshake_regs cfg_hs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .rd_valid_o  (rd_valid_o),
    .eng_start_o (eng_start_o),
    .eng_mode_o  (eng_mode_o),
    .eng_done_i  (eng_done_i),
    .host_owns_o (host_owns_o),
    .start_q     (start_q),
    .done_q      (done_q)
);

// File: tb/cfg_handshake_regs_test.sv
module cfg_handshake_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [11:0] req_addr_i = '0;
    logic [31:0] req_wdata_i = '0;
    logic        rd_valid_o;
    logic [31:0] rd_data_o;
    logic [31:0] fw_version_i = 32'h3210_0000;
    logic        eng_start_o;
    logic [15:0] eng_mode_o;
    logic        eng_done_i = 1'b0;
    logic [15:0] grp_a_stat_i = '0;
    logic [15:0] grp_b_stat_i = '0;
    logic        host_owns_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cfg_handshake_regs uut (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .fw_version_i(fw_version_i),
        .eng_start_o(eng_start_o), .eng_mode_o(eng_mode_o),
        .eng_done_i(eng_done_i),
        .grp_a_stat_i(grp_a_stat_i), .grp_b_stat_i(grp_b_stat_i),
        .host_owns_o(host_owns_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // write issued at a rising edge; returns at the following falling edge
    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_wdata_i = d;
        @(negedge clk);
        req_valid_i = 1'b0; req_write_i = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk("R10 rd_valid", {31'b0, rd_valid_o}, 32'd1);
        d = rd_data_o;
    endtask

    function automatic logic [15:0] pattern(input int p);
        logic [15:0] m;
        for (int i = 0; i < 8; i++) m[2*i +: 2] = 2'((p + i) % 4);
        return m;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [15:0] m;
        logic [15:0] m2;
        for (int p = 0; p < 4; p++) begin
            fw_version_i = 32'h3210_0000;
            do_reset();
            // R1 reset state
            do_read(12'h000, d); chk("R1 ctrl reset", d, 32'h0);
            do_read(12'h008, d); chk("R1 grpA reset", d, 32'h0);
            do_read(12'h00C, d); chk("R1 grpB reset", d, 32'h0);
            chk("R1 launch low", {31'b0, eng_start_o}, 32'd0);
            chk("R1 owner low", {31'b0, host_owns_o}, 32'd0);
            // R6 done ignored with no pending request
            @(negedge clk); eng_done_i = 1'b1;
            @(negedge clk); eng_done_i = 1'b0;
            chk("R6 stray done owner", {31'b0, host_owns_o}, 32'd0);
            // R5 write without request bit ignored
            m = pattern(p);
            do_write(12'h000, {8'h0, m, 8'h00});
            chk("R5 no-start no launch", {31'b0, eng_start_o}, 32'd0);
            do_read(12'h000, d); chk("R5 no-start ignored", d, 32'h0);
            // R3/R4 accepted request, all garbage bits set
            do_write(12'h000, {8'hFF, m, 8'hFE});
            chk("R3 launch pulse", {31'b0, eng_start_o}, 32'd1);
            chk("R4 mode out", {16'h0, eng_mode_o}, {16'h0, m});
            @(negedge clk);
            chk("R3 launch single", {31'b0, eng_start_o}, 32'd0);
            do_read(12'h000, d); chk("R2 ctrl layout", d, {8'h0, m, 8'h02});
            // R5 second request dropped
            m2 = ~m;
            do_write(12'h000, {8'h0, m2, 8'h02});
            chk("R5 no relaunch", {31'b0, eng_start_o}, 32'd0);
            do_read(12'h000, d); chk("R5 modes kept", d, {8'h0, m, 8'h02});
            // R6/R7/R9 completion
            @(negedge clk);
            grp_a_stat_i = {8'h00, 8'(8'hA0 + p)};
            grp_b_stat_i = {8'(8'h30 + p), 8'h07};
            eng_done_i = 1'b1;
            @(negedge clk);
            eng_done_i = 1'b0;
            chk("R7 owner after done", {31'b0, host_owns_o}, 32'd1);
            grp_a_stat_i = 16'hFFFF; grp_b_stat_i = 16'hFFFF;
            do_read(12'h000, d); chk("R6 done flag", d, {8'h0, m, 8'h03});
            do_read(12'h008, d); chk("R9 grpA", d, {16'h0, 8'h00, 8'(8'hA0 + p)});
            do_read(12'h00C, d); chk("R9 grpB", d, {16'h0, 8'(8'h30 + p), 8'h07});
            do_write(12'h000, {8'h0, m2, 8'h02});
            chk("R5 after done no launch", {31'b0, eng_start_o}, 32'd0);
            do_read(12'h000, d); chk("R5 after done kept", d, {8'h0, m, 8'h03});
            // R8 version fields
            fw_version_i = {4'(p + 1), 4'(p + 2), 4'(p + 3), 20'h0};
            do_read(12'h004, d);
            chk("R8 major", {28'h0, d[31:28]}, 32'(p + 1));
            chk("R8 minor", {28'h0, d[27:24]}, 32'(p + 2));
            chk("R8 patch", {28'h0, d[23:20]}, 32'(p + 3));
        end
        // R7 version zero grants ownership without completion
        fw_version_i = 32'h0;
        do_reset();
        @(negedge clk);
        chk("R7 no controller owner", {31'b0, host_owns_o}, 32'd1);
        fw_version_i = 32'h1000_0000;
        #1 chk("R7 controller present owner", {31'b0, host_owns_o}, 32'd0);
        // R10 address sweep
        for (int a = 0; a < 64; a++) begin
            logic [31:0] e;
            e = (a == 4) ? 32'h1000_0000 : 32'h0;
            do_read(12'(a), d);
            chk("R10 addr sweep", d, e);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule